// File: doc/BRIEF.md
# Presettable Saturating Error Counter Bank

This block keeps four error tallies for a T1 receive monitor: bipolar violations (or excessive-zero runs), CRC6 word errors, out-of-frame events and framing-bit errors. The line-side logic delivers one-cycle event pulses. The block qualifies each pulse against the current frame mode, zero-substitution setting and sync state, then adds it to its tally. A tally never wraps. It starts from a value the host loaded and stops at all-ones. Every event that arrives after a tally is full raises a one-cycle saturation pulse, which the alarm status logic can latch.

The host reaches the tallies through byte-wide registers. A read lasts as long as `host_rd` is held high. On the first cycle of a read, the addressed byte is copied into a holding register. All four tallies are frozen for the whole read. Events that arrive during the read are collected in small per-counter pending tallies. These are folded in when the read ends, so nothing is lost. If auto-clear was set when the read started, all four tallies restart from zero before the pending events are added.

Top module: `errcnt_bank`

## Requirements
- R1: After reset every tally, the holding register, the low-byte staging register and every pending tally are zero, so all five registers read 0x00 and `sat_pulse` is 0.
- R2: Outside a read, each qualified event adds one to its tally. A tally that is at all-ones (0xFFFF for the wide one, 0xFF for the narrow ones) stays there.
- R3: An event that reaches a counter whose projected value is already all-ones drives that counter's `sat_pulse` bit high in the same cycle. The bits are: bit0 wide tally, bit1 CRC, bit2 OOF, bit3 frame-bit. The projected value is the base plus pending, where the base is zero when auto-clear applies to the current read.
- R4: The register addresses are: 0 wide tally low byte, 1 wide tally high byte, 2 CRC, 3 OOF, 4 frame-bit. A write to address 0 only stages the byte. A write to address 1 loads the full 16-bit value, with the staged byte as the low byte and the written byte as the high byte.
- R5: The wide tally's event source depends on the modes. With `xz_sel`=0 it counts `ev_bpv`, except when `b8zs_en`=1 and `ev_cw` is also high. With `xz_sel`=1 it counts `ev_zero8` when `b8zs_en`=1, or `ev_zero16` when `b8zs_en`=0.
- R6: While `los` is high, CRC, OOF and frame-bit events are ignored. Wide tally events are still counted.
- R7: While `esf_mode` is 0, the CRC tally is held at zero and writes to address 2 have no effect.
- R8: `host_rdata` returns the addressed byte as it stood in the cycle `host_rd` rose. It holds that value until the next read starts. With `auto_clr`=0, a read leaves every tally unchanged.
- R9: While `host_rd` is high the tallies are frozen and qualified events go into pending tallies. Each pending tally holds at most 2^PEND_W-1 events. In the cycle after `host_rd` falls, each tally becomes base plus pending plus that cycle's event, capped at all-ones.
- R10: If `auto_clr` is high in the cycle a read starts, the base of all four tallies is zero when the read ends, so each tally then holds only the events counted during the read.
- R11: A host write and an event to the same counter in the same cycle leave the written value. The write also discards that counter's pending events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_bpv | input | 1 | Bipolar violation pulse |
| ev_cw | input | 1 | Violation belongs to a zero-substitution codeword |
| ev_zero8 | input | 1 | Run of 8 zeros pulse |
| ev_zero16 | input | 1 | Run of 16 zeros pulse |
| ev_crc | input | 1 | CRC6 word error pulse |
| ev_oof | input | 1 | Out-of-frame event pulse |
| ev_fbit | input | 1 | Framing-bit error pulse |
| esf_mode | input | 1 | 1 = extended superframe, 0 = superframe |
| b8zs_en | input | 1 | Zero-substitution decoding enabled |
| xz_sel | input | 1 | Wide tally counts zero runs instead of violations |
| auto_clr | input | 1 | Clear all tallies at the end of a read |
| los | input | 1 | Loss of sync |
| host_rd | input | 1 | High for the duration of a host read |
| host_wr | input | 1 | One-cycle host write strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Holding register (snapshot of addressed byte) |
| sat_pulse | output | 4 | Per-counter saturation event pulses |

## Verification
The bench builds the block with PEND_W=3, so a pending tally fills after seven events. A nine-event read can then show the pending cap. The wide tally keeps its full 16 bits and the narrow ones stay at 8. Host presets place each tally a few events below all-ones, so saturation, the cap applied when a read ends and the saturation pulses during a read all occur in a few hundred cycles. A behavioural model checks `sat_pulse` and `host_rdata` on every clock, next to directed reads.

// File: rtl/errcnt_pkg.sv
package errcnt_pkg;
   localparam int NUM_CNT = 4;

   typedef enum logic [2:0] {
      A_WIDE_LO = 3'd0,
      A_WIDE_HI = 3'd1,
      A_CRC     = 3'd2,
      A_OOF     = 3'd3,
      A_FBIT    = 3'd4
   } reg_addr_e;

   localparam int IX_WIDE = 0;
   localparam int IX_CRC  = 1;
   localparam int IX_OOF  = 2;
   localparam int IX_FBIT = 3;
endpackage

// File: rtl/errcnt_qual.sv
module errcnt_qual (
   input  logic       ev_bpv,
   input  logic       ev_cw,
   input  logic       ev_zero8,
   input  logic       ev_zero16,
   input  logic       ev_crc,
   input  logic       ev_oof,
   input  logic       ev_fbit,
   input  logic       esf_mode,
   input  logic       b8zs_en,
   input  logic       xz_sel,
   input  logic       los,
   output logic [3:0] ev_q
);
   import errcnt_pkg::*;

   logic viol_ok;
   logic zero_ok;

   always_comb begin
      viol_ok           = ev_bpv & ~(b8zs_en & ev_cw);
      zero_ok           = b8zs_en ? ev_zero8 : ev_zero16;
      ev_q[IX_WIDE]     = xz_sel ? zero_ok : viol_ok;
      ev_q[IX_CRC]      = ev_crc & esf_mode & ~los;
      ev_q[IX_OOF]      = ev_oof & ~los;
      ev_q[IX_FBIT]     = ev_fbit & ~los;
   end
endmodule

// File: rtl/errcnt_cell.sv
module errcnt_cell #(
   parameter int W      = 8,
   parameter int PEND_W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ev,
   input  logic         hold_zero,
   input  logic         in_rd,
   input  logic         fin,
   input  logic         clr_eff,
   input  logic         wr_en,
   input  logic [W-1:0] wr_val,
   output logic [W-1:0] cnt,
   output logic         sat_pulse
);
   localparam logic [W:0]        MAXV = {1'b0, {W{1'b1}}};
   localparam logic [PEND_W-1:0] PMAX = '1;

   generate
      if (PEND_W < 1 || PEND_W >= W) begin : g_bad_pend
         $error("errcnt_cell: PEND_W must be in 1..W-1");
      end
   endgenerate

   logic [W-1:0]      cnt_q;
   logic [PEND_W-1:0] pend_q;
   logic [W:0]        base;
   logic [W:0]        proj;
   logic [W:0]        fin_sum;
   logic              full;

   always_comb begin
      base      = ((in_rd | fin) & clr_eff) ? '0 : {1'b0, cnt_q};
      proj      = base + (W+1)'(pend_q);
      full      = (proj >= MAXV);
      fin_sum   = proj + (W+1)'(ev);
      sat_pulse = ev & full & ~wr_en & ~hold_zero;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pend_q <= '0;
      end else if (hold_zero) begin
         cnt_q  <= '0;
         pend_q <= '0;
      end else if (wr_en) begin
         cnt_q  <= wr_val;
         pend_q <= '0;
      end else if (in_rd) begin
         if (ev && !full && pend_q != PMAX) pend_q <= pend_q + 1'b1;
      end else if (fin) begin
         cnt_q  <= (fin_sum >= MAXV) ? MAXV[W-1:0] : fin_sum[W-1:0];
         pend_q <= '0;
      end else if (ev && !full) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign cnt = cnt_q;

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == MAXV[W-1:0] && !wr_en && !hold_zero && !(fin && clr_eff)) |=> cnt_q == MAXV[W-1:0]); // R2
   AST_SAT_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_pulse && !in_rd && !fin) |-> cnt_q == MAXV[W-1:0]); // R3
   AST_FROZEN_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (in_rd && !wr_en && !hold_zero) |=> cnt_q == $past(cnt_q)); // R9
   AST_PEND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_rd && !fin) |-> pend_q == '0); // R9
endmodule

// File: rtl/errcnt_bank.sv
module errcnt_bank #(
   parameter int BV_W   = 16,
   parameter int CNT_W  = 8,
   parameter int PEND_W = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_bpv,
   input  logic       ev_cw,
   input  logic       ev_zero8,
   input  logic       ev_zero16,
   input  logic       ev_crc,
   input  logic       ev_oof,
   input  logic       ev_fbit,
   input  logic       esf_mode,
   input  logic       b8zs_en,
   input  logic       xz_sel,
   input  logic       auto_clr,
   input  logic       los,
   input  logic       host_rd,
   input  logic       host_wr,
   input  logic [2:0] host_addr,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata,
   output logic [3:0] sat_pulse
);
   import errcnt_pkg::*;

   generate
      if (BV_W < 9 || BV_W > 16) begin : g_bad_bv
         $error("errcnt_bank: BV_W must be in 9..16");
      end
      if (CNT_W < 2 || CNT_W > 8) begin : g_bad_cnt
         $error("errcnt_bank: CNT_W must be in 2..8");
      end
   endgenerate

   logic [3:0]  ev_q;
   logic        rd_q;
   logic        clr_lat;
   logic        fin;
   logic        clr_eff;
   logic [7:0]  stage_q;
   logic [7:0]  hold_q;
   logic [3:0]  wr_vec;
   logic [15:0] cnt_bus [NUM_CNT];

   errcnt_qual u_qual (
      .ev_bpv    (ev_bpv),
      .ev_cw     (ev_cw),
      .ev_zero8  (ev_zero8),
      .ev_zero16 (ev_zero16),
      .ev_crc    (ev_crc),
      .ev_oof    (ev_oof),
      .ev_fbit   (ev_fbit),
      .esf_mode  (esf_mode),
      .b8zs_en   (b8zs_en),
      .xz_sel    (xz_sel),
      .los       (los),
      .ev_q      (ev_q)
   );

   always_comb begin
      fin     = rd_q & ~host_rd;
      clr_eff = rd_q ? clr_lat : auto_clr;
      wr_vec[IX_WIDE] = host_wr && host_addr == A_WIDE_HI;
      wr_vec[IX_CRC]  = host_wr && host_addr == A_CRC;
      wr_vec[IX_OOF]  = host_wr && host_addr == A_OOF;
      wr_vec[IX_FBIT] = host_wr && host_addr == A_FBIT;
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
         localparam int W = (gi == IX_WIDE) ? BV_W : CNT_W;
         logic [W-1:0] wv;
         logic [W-1:0] c;
         if (gi == IX_WIDE) begin : g_wide
            assign wv = W'({host_wdata, stage_q});
         end else begin : g_narrow
            assign wv = W'(host_wdata);
         end
         errcnt_cell #(.W(W), .PEND_W(PEND_W)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .ev        (ev_q[gi]),
            .hold_zero ((gi == IX_CRC) ? ~esf_mode : 1'b0),
            .in_rd     (host_rd),
            .fin       (fin),
            .clr_eff   (clr_eff),
            .wr_en     (wr_vec[gi]),
            .wr_val    (wv),
            .cnt       (c),
            .sat_pulse (sat_pulse[gi])
         );
         assign cnt_bus[gi] = 16'(c);
      end
   endgenerate

   logic [15:0] sel_word;
   logic [7:0]  sel_byte;

   always_comb begin
      case (host_addr)
         A_WIDE_LO, A_WIDE_HI: sel_word = cnt_bus[IX_WIDE];
         A_CRC:                sel_word = cnt_bus[IX_CRC];
         A_OOF:                sel_word = cnt_bus[IX_OOF];
         A_FBIT:               sel_word = cnt_bus[IX_FBIT];
         default:              sel_word = '0;
      endcase
      sel_byte = (host_addr == A_WIDE_HI) ? sel_word[15:8] : sel_word[7:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q    <= 1'b0;
         clr_lat <= 1'b0;
         stage_q <= '0;
         hold_q  <= '0;
      end else begin
         rd_q <= host_rd;
         if (host_rd && !rd_q) begin
            clr_lat <= auto_clr;
            hold_q  <= sel_byte;
         end
         if (host_wr && host_addr == A_WIDE_LO) stage_q <= host_wdata;
      end
   end

   assign host_rdata = hold_q;

   AST_LOS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      los |-> sat_pulse[3:1] == 3'b000); // R6
   AST_CRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !esf_mode |=> cnt_bus[IX_CRC] == 16'h0); // R7
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_rd && !rd_q) |=> $stable(host_rdata)); // R8
endmodule

// File: tb/errcnt_bank_test.sv
`timescale 1ns/1ps
module errcnt_bank_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_bpv = 0, ev_cw = 0, ev_zero8 = 0, ev_zero16 = 0;
   logic ev_crc = 0, ev_oof = 0, ev_fbit = 0;
   logic esf_mode = 1, b8zs_en = 0, xz_sel = 0, auto_clr = 0, los = 0;
   logic host_rd = 0, host_wr = 0;
   logic [2:0] host_addr = 0;
   logic [7:0] host_wdata = 0;
   logic [7:0] host_rdata;
   logic [3:0] sat_pulse;

   always #2.5 clk = ~clk;

   errcnt_bank #(.BV_W(16), .CNT_W(8), .PEND_W(3)) uut (
      .clk(clk), .rst_n(rst_n),
      .ev_bpv(ev_bpv), .ev_cw(ev_cw), .ev_zero8(ev_zero8), .ev_zero16(ev_zero16),
      .ev_crc(ev_crc), .ev_oof(ev_oof), .ev_fbit(ev_fbit),
      .esf_mode(esf_mode), .b8zs_en(b8zs_en), .xz_sel(xz_sel),
      .auto_clr(auto_clr), .los(los),
      .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .sat_pulse(sat_pulse)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // behavioural model
   int mcnt [4];
   int mpend [4];
   int mmax [4] = '{65535, 255, 255, 255};
   int mhold = 0, mstage = 0;
   bit mrdq = 0, mclr = 0;
   localparam int PM = 7;

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      bit [3:0] qe, es;
      int nc [4], np [4];
      bit fin, ce, wr;
      int base, proj, wv, nh, word;
      #1.5;
      qe[0] = xz_sel ? (b8zs_en ? ev_zero8 : ev_zero16) : (ev_bpv && !(b8zs_en && ev_cw));
      qe[1] = ev_crc && esf_mode && !los;
      qe[2] = ev_oof && !los;
      qe[3] = ev_fbit && !los;
      fin = mrdq && !host_rd;
      ce  = mrdq ? mclr : auto_clr;
      for (int i = 0; i < 4; i++) begin
         wr = host_wr && (host_addr == 3'(i + 1));
         wv = (i == 0) ? host_wdata * 256 + mstage : host_wdata;
         base = ((host_rd || fin) && ce) ? 0 : mcnt[i];
         proj = base + mpend[i];
         es[i] = qe[i] && proj >= mmax[i] && !wr && !(i == 1 && !esf_mode);
         nc[i] = mcnt[i]; np[i] = mpend[i];
         if (i == 1 && !esf_mode) begin nc[i] = 0; np[i] = 0; end
         else if (wr) begin nc[i] = wv; np[i] = 0; end
         else if (host_rd) begin
            if (qe[i] && proj < mmax[i] && mpend[i] < PM) np[i] = mpend[i] + 1;
         end else if (fin) begin
            nc[i] = (proj + qe[i] > mmax[i]) ? mmax[i] : proj + qe[i];
            np[i] = 0;
         end else if (qe[i] && proj < mmax[i]) nc[i] = mcnt[i] + 1;
      end
      chk("R3 sat_pulse", sat_pulse, es);
      chk("R8 host_rdata", host_rdata, mhold);
      nh = mhold;
      if (host_rd && !mrdq) begin
         word = (host_addr <= 1) ? mcnt[0] : (host_addr <= 4) ? mcnt[host_addr - 1] : 0;
         nh = (host_addr == 1) ? (word >> 8) & 255 : word & 255;
         mclr = auto_clr;
      end
      @(posedge clk);
      for (int i = 0; i < 4; i++) begin mcnt[i] = nc[i]; mpend[i] = np[i]; end
      mhold = nh;
      if (host_wr && host_addr == 0) mstage = host_wdata;
      mrdq = host_rd;
      @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      host_addr = 3'(a); host_wdata = 8'(d); host_wr = 1;
      step();
      host_wr = 0;
   endtask

   task automatic rd_begin(input int a);
      host_addr = 3'(a); host_rd = 1;
      step();
   endtask

   task automatic rd_end(input int exp, string req);
      host_rd = 0;
      chk(req, host_rdata, exp);
      step();
   endtask

   task automatic rd(input int a, input int exp, string req);
      rd_begin(a);
      rd_end(exp, req);
   endtask

   // m bits: 0 bpv, 1 cw, 2 zero8, 3 zero16, 4 crc, 5 oof, 6 fbit
   task automatic evp(input bit [6:0] m, input bit [3:0] exps, string req);
      {ev_fbit, ev_oof, ev_crc, ev_zero16, ev_zero8, ev_cw, ev_bpv} = m;
      #0.5;
      chk(req, sat_pulse, exps);
      step();
      {ev_fbit, ev_oof, ev_crc, ev_zero16, ev_zero8, ev_cw, ev_bpv} = '0;
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) begin mcnt[i] = 0; mpend[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 5; a++) rd(a, 0, "R1");
      // R4 split preset
      wr(0, 8'h34);
      rd(0, 0, "R4 staged only");
      wr(1, 8'h12);
      rd(0, 8'h34, "R4 low");
      rd(1, 8'h12, "R4 high");
      // R2 counting
      repeat (3) evp(7'h01, 4'h0, "R2");
      rd(0, 8'h37, "R2 count");
      wr(0, 8'hFE); wr(1, 8'hFF);
      evp(7'h01, 4'h0, "R2");
      evp(7'h01, 4'h1, "R3 sat");
      evp(7'h01, 4'h1, "R3 sat");
      rd(0, 8'hFF, "R2 no wrap");
      rd(1, 8'hFF, "R2 no wrap");
      // R5 source selection
      wr(0, 0); wr(1, 0);
      xz_sel = 1; b8zs_en = 1;
      evp(7'h01, 4'h0, "R5"); evp(7'h08, 4'h0, "R5"); evp(7'h04, 4'h0, "R5");
      rd(0, 1, "R5 zero8");
      xz_sel = 0;
      evp(7'h03, 4'h0, "R5"); evp(7'h01, 4'h0, "R5");
      rd(0, 2, "R5 codeword skip");
      b8zs_en = 0; xz_sel = 1;
      evp(7'h08, 4'h0, "R5"); evp(7'h04, 4'h0, "R5");
      rd(0, 3, "R5 zero16");
      xz_sel = 0;
      // R6 loss of sync
      los = 1;
      evp(7'h10, 4'h0, "R6"); evp(7'h20, 4'h0, "R6");
      evp(7'h40, 4'h0, "R6"); evp(7'h01, 4'h0, "R6");
      los = 0;
      rd(2, 0, "R6 crc"); rd(3, 0, "R6 oof"); rd(4, 0, "R6 fbit"); rd(0, 4, "R6 wide");
      // R7 superframe
      esf_mode = 0;
      evp(7'h10, 4'h0, "R7");
      wr(2, 5);
      rd(2, 0, "R7 held");
      esf_mode = 1;
      evp(7'h10, 4'h0, "R7");
      rd(2, 1, "R7 esf");
      // R11 write wins
      host_addr = 3; host_wdata = 10; host_wr = 1; ev_oof = 1;
      step();
      host_wr = 0; ev_oof = 0;
      rd(3, 10, "R11");
      // R8/R9 snapshot and pending
      wr(4, 8'hFD);
      rd_begin(4);
      evp(7'h40, 4'h0, "R9"); evp(7'h40, 4'h0, "R9"); evp(7'h40, 4'h8, "R3 in read");
      rd_end(8'hFD, "R8 snapshot");
      rd(4, 8'hFF, "R9 applied");
      rd(4, 8'hFF, "R8 no clear");
      // R9 pending cap
      wr(3, 0);
      rd_begin(3);
      repeat (9) evp(7'h20, 4'h0, "R9");
      rd_end(0, "R9");
      rd(3, 7, "R9 cap");
      // R10 auto clear
      wr(2, 20);
      auto_clr = 1;
      rd_begin(3);
      auto_clr = 0;
      evp(7'h10, 4'h0, "R10"); evp(7'h10, 4'h0, "R10");
      rd_end(7, "R10 snapshot");
      rd(2, 2, "R10 crc"); rd(3, 0, "R10 oof"); rd(4, 0, "R10 fbit");
      rd(0, 0, "R10 wide lo"); rd(1, 0, "R10 wide hi");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule